// File: doc/BRIEF.md
# Variable-Length Instruction Boundary Predecoder

This block sits between an instruction fetch buffer and the instruction decoder. It takes a raw instruction byte stream as a valid/ready sequence of 16-bit parcels. Instruction bytes are always read in big-endian order, so the major opcode of every instruction lies in the top six bits of its first parcel. The block reads that opcode from the first parcel and works out how many parcels the instruction spans. It collects those parcels and then presents the whole instruction, left-aligned in a 64-bit word, together with a 3-bit class tag.

While the escape-mode input is high, an opcode whose upper three bits are zero selects one of four extended length classes. The class is picked in pairs by the opcode's low three bits: 16-bit compressed, 48-bit prefixed, 64-bit prefixed, and variable-length block header. All other opcodes, and every opcode while escape mode is low, mean a plain 32-bit instruction. A block header is emitted as one parcel with its tag, and the consumer walks the rest of the block itself. A synchronous flush drops any partly built or waiting instruction, and the next parcel is then classified as a fresh first parcel.

Top module: `ilen_predecode`

## Requirements
- R1: The major opcode is bits [15:10] of an instruction's first parcel. With escape mode high, opcodes 0 and 1 give class code 0 (compressed) and the instruction is one parcel long.
- R2: With escape mode high, opcodes 2 and 3 give class code 2 (48-bit prefixed), three parcels.
- R3: With escape mode high, opcodes 4 and 5 give class code 3 (64-bit prefixed), four parcels.
- R4: With escape mode high, opcodes 6 and 7 give class code 4 (block header), one parcel.
- R5: Opcodes 8 to 63 with any escape setting, and every opcode with escape mode low, give class code 1 (plain 32-bit), two parcels.
- R6: `out_insn` holds the first parcel in bits [63:48] and the later parcels below it in arrival order. Bits below the last parcel are zero.
- R7: `out_valid` rises in the cycle after the final parcel of an instruction is accepted, and not before. `in_ready` is low while `out_valid` is high.
- R8: While `out_valid` is high and `out_ready` is low, `out_insn` and `out_class` hold steady. After a cycle with both high, `out_valid` is low.
- R9: Escape mode is sampled with the first parcel only. Changing it while later parcels of the same instruction arrive does not alter the class.
- R10: `flush` drops any partial or waiting instruction (`out_valid` low and `in_ready` high in the next cycle). The next accepted parcel is classified as a first parcel.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop partial or pending instruction |
| esc_en | input | 1 | Escape mode: enables the extended length classes |
| in_valid | input | 1 | Parcel valid |
| in_ready | output | 1 | Parcel accepted when high with in_valid |
| in_parcel | input | 16 | Instruction parcel, big-endian byte order |
| out_valid | output | 1 | Assembled instruction valid |
| out_ready | input | 1 | Consumer takes the instruction |
| out_insn | output | 64 | Instruction, left-aligned |
| out_class | output | 3 | Class tag: 0 compressed, 1 plain, 2 prefixed-48, 3 prefixed-64, 4 block header |

## Verification
The bench builds the block with its default 16-bit parcel width. With that width the six-bit opcode space has only 64 values, so the bench sends every opcode under both escape settings, with payload patterns that vary from instruction to instruction. This reaches every class boundary (opcodes 7 and 8, and each pair edge) and every instruction length. The bench also exercises output back-pressure, an escape change in the middle of an instruction, and flushes that hit both a half-built instruction and one already waiting at the output.

// File: rtl/ilen_pkg.sv
package ilen_pkg;
  localparam int unsigned OPC_W       = 6;
  localparam int unsigned MAX_PARCELS = 4;
  localparam int unsigned CNT_W       = $clog2(MAX_PARCELS + 1);

  typedef enum logic [2:0] {
    ILC_C16  = 3'd0,
    ILC_W32  = 3'd1,
    ILC_P48  = 3'd2,
    ILC_P64  = 3'd3,
    ILC_VBLK = 3'd4
  } ilen_cls_e;

  // Length class from the major opcode; escape gates the extended classes.
  function automatic ilen_cls_e class_of(input logic [OPC_W-1:0] opc, input logic esc);
    ilen_cls_e c;
    c = ILC_W32;
    if (esc && (opc[OPC_W-1:3] == '0)) begin
      case (opc[2:1])
        2'd0:    c = ILC_C16;
        2'd1:    c = ILC_P48;
        2'd2:    c = ILC_P64;
        default: c = ILC_VBLK;
      endcase
    end
    return c;
  endfunction

  // Number of parcels the block gathers for a class.
  function automatic logic [CNT_W-1:0] parcels_of(input ilen_cls_e c);
    logic [CNT_W-1:0] n;
    case (c)
      ILC_C16:  n = CNT_W'(1);
      ILC_W32:  n = CNT_W'(2);
      ILC_P48:  n = CNT_W'(3);
      ILC_P64:  n = CNT_W'(4);
      default:  n = CNT_W'(1);
    endcase
    return n;
  endfunction
endpackage

// File: rtl/ilen_classify.sv
module ilen_classify
  import ilen_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  input  logic             esc,
  output ilen_cls_e        cls,
  output logic [CNT_W-1:0] nparc
);
  always_comb begin
    cls   = class_of(opc, esc);
    nparc = parcels_of(cls);
  end
endmodule

// File: rtl/ilen_assemble.sv
module ilen_assemble
  import ilen_pkg::*;
#(
  parameter int unsigned PARCEL_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            flush,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic [PARCEL_W-1:0]             in_parcel,
  input  ilen_cls_e                       cls_in,
  input  logic [CNT_W-1:0]                need_in,
  output logic                            first_parcel,
  output logic                            out_valid,
  input  logic                            out_ready,
  output logic [PARCEL_W*MAX_PARCELS-1:0] out_insn,
  output ilen_cls_e                       out_class
);
  localparam int unsigned INSN_W = PARCEL_W * MAX_PARCELS;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] need_q;
  ilen_cls_e        cls_q;
  logic             vld_q;

  // Named events for the checker and readability.
  logic             accept;
  logic             last_parcel;
  logic [CNT_W-1:0] need_now;

  assign in_ready     = !vld_q;
  assign accept       = in_valid && in_ready;
  assign first_parcel = (cnt_q == '0);
  assign need_now     = first_parcel ? need_in : need_q;
  assign last_parcel  = accept && ((cnt_q + CNT_W'(1)) == need_now);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      cnt_q  <= '0;
      vld_q  <= 1'b0;
      need_q <= '0;
      cls_q  <= ILC_W32;
    end else begin
      if (accept && first_parcel) begin
        need_q <= need_in;
        cls_q  <= cls_in;
      end
      if (last_parcel) begin
        cnt_q <= '0;
      end else if (accept) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
      if (last_parcel) begin
        vld_q <= 1'b1;
      end else if (out_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  generate
    for (genvar g = 0; g < MAX_PARCELS; g++) begin : g_slot
      logic [PARCEL_W-1:0] slot_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          slot_q <= '0;
        end else if (accept && (cnt_q == CNT_W'(g))) begin
          slot_q <= in_parcel;
        end else if (accept && first_parcel) begin
          slot_q <= '0;
        end
      end
      assign out_insn[INSN_W-1-g*PARCEL_W -: PARCEL_W] = slot_q;
    end
  endgenerate

  assign out_valid = vld_q;
  assign out_class = cls_q;
endmodule

// File: rtl/ilen_predecode.sv
module ilen_predecode
  import ilen_pkg::*;
#(
  parameter int unsigned PARCEL_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            flush,
  input  logic                            esc_en,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic [PARCEL_W-1:0]             in_parcel,
  output logic                            out_valid,
  input  logic                            out_ready,
  output logic [PARCEL_W*MAX_PARCELS-1:0] out_insn,
  output logic [2:0]                      out_class
);
  ilen_cls_e        cls_w;
  ilen_cls_e        out_cls_w;
  logic [CNT_W-1:0] need_w;
  logic             first_w;

  ilen_classify u_classify (
    .opc   (in_parcel[PARCEL_W-1 -: OPC_W]),
    .esc   (esc_en),
    .cls   (cls_w),
    .nparc (need_w)
  );

  ilen_assemble #(.PARCEL_W(PARCEL_W)) u_assemble (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_parcel    (in_parcel),
    .cls_in       (cls_w),
    .need_in      (need_w),
    .first_parcel (first_w),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_insn     (out_insn),
    .out_class    (out_cls_w)
  );

  assign out_class = out_cls_w;

  logic unused_first;
  assign unused_first = first_w;
endmodule

// File: rtl/ilen_predecode_chk.sv
module ilen_predecode_chk
  import ilen_pkg::*;
#(
  parameter int unsigned PARCEL_W = 16
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            flush,
  input logic                            in_ready,
  input logic                            out_valid,
  input logic                            out_ready,
  input logic [PARCEL_W*MAX_PARCELS-1:0] out_insn,
  input logic [2:0]                      out_class
);
  localparam int unsigned IW = PARCEL_W * MAX_PARCELS;

  // R7
  busy_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R8
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n || flush)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_insn) && $stable(out_class)));

  // R8
  drop_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);

  // R10
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!out_valid && in_ready));

  // R6
  short_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_class == 3'(ILC_C16) || out_class == 3'(ILC_VBLK)))
      |-> (out_insn[IW-PARCEL_W-1:0] == '0));

  // R6
  p48_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == 3'(ILC_P48)) |-> (out_insn[PARCEL_W-1:0] == '0));

  // R1
  ext_opcode_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class != 3'(ILC_W32)) |-> (out_insn[IW-1 -: 3] == 3'b000));

  // R5
  legal_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_class <= 3'(ILC_VBLK)));
endmodule

bind ilen_predecode ilen_predecode_chk #(.PARCEL_W(PARCEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_insn  (out_insn),
  .out_class (out_class)
);

// File: tb/ilen_predecode_bench.sv
module ilen_predecode_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        esc_en = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_parcel = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_insn;
  logic [2:0]  out_class;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ilen_predecode u_ilen_predecode (
    .clk(clk), .rst_n(rst_n), .flush(flush), .esc_en(esc_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_parcel(in_parcel),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_insn(out_insn), .out_class(out_class)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Class code by the rules: pairs below 8 under escape, else plain.
  function automatic int exp_cls(input int opc, input bit esc);
    if (esc && opc < 8) begin
      case (opc / 2)
        0:       return 0;
        1:       return 2;
        2:       return 3;
        default: return 4;
      endcase
    end
    return 1;
  endfunction

  function automatic int exp_len(input int c);
    case (c)
      1:       return 2;
      2:       return 3;
      3:       return 4;
      default: return 1;
    endcase
  endfunction

  task automatic send(input logic [15:0] p);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid  = 1'b1;
    in_parcel = p;
    @(negedge clk);
    in_valid  = 1'b0;
  endtask

  task automatic run_insn(input int opc, input bit esc, input bit esc_late,
                          input int seed, input int stall, input string tag);
    logic [15:0] p [4];
    logic [63:0] exp;
    int c, n;
    c = exp_cls(opc, esc);
    n = exp_len(c);
    p[0] = {opc[5:0], 10'(seed * 7 + 3)};
    for (int k = 1; k < 4; k++) p[k] = 16'(seed * 131 + k * 4099 + 16'h5a00);
    exp = '0;
    for (int k = 0; k < n; k++) exp[63 - 16*k -: 16] = p[k];
    esc_en = esc;
    for (int k = 0; k < n; k++) begin
      send(p[k]);
      if (k == 0) esc_en = esc_late;
      if (k < n - 1) chk({"R7 early valid ", tag}, 64'(out_valid), 64'd0);
    end
    chk({"R7 valid after last ", tag}, 64'(out_valid), 64'd1);
    chk({"R7 ready low ", tag}, 64'(in_ready), 64'd0);
    chk({tag, " class"}, 64'(out_class), 64'(c));
    chk({"R6 insn ", tag}, out_insn, exp);
    for (int s = 0; s < stall; s++) @(negedge clk);
    if (stall > 0) begin
      chk("R8 held valid", 64'(out_valid), 64'd1);
      chk("R8 held insn", out_insn, exp);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R8 dropped after take", 64'(out_valid), 64'd0);
  endtask

  function automatic string tag_of(input int opc, input bit esc);
    int c;
    c = exp_cls(opc, esc);
    case (c)
      0:       return "R1";
      2:       return "R2";
      3:       return "R3";
      4:       return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #3000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11
    chk("R11 reset out_valid", 64'(out_valid), 64'd0);
    chk("R11 reset in_ready", 64'(in_ready), 64'd1);

    // Full opcode sweep, both escape settings (R1 R2 R3 R4 R5 R6 R7 R8).
    for (int e = 0; e < 2; e++) begin
      for (int opc = 0; opc < 64; opc++) begin
        run_insn(opc, bit'(e), bit'(e), opc + 64 * e, (opc % 3), tag_of(opc, bit'(e)));
      end
    end

    // R9: escape toggled after the first parcel leaves the class alone.
    run_insn(4, 1'b1, 1'b0, 900, 0, "R9 late esc off");
    run_insn(9, 1'b0, 1'b1, 901, 1, "R9 late esc on");
    run_insn(2, 1'b0, 1'b1, 902, 0, "R9 esc on after plain");

    // R10: flush in the middle of a 64-bit instruction.
    esc_en = 1'b1;
    send({6'd4, 10'h155});
    send(16'hbeef);
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    chk("R10 flush partial ready", 64'(in_ready), 64'd1);
    chk("R10 flush partial valid", 64'(out_valid), 64'd0);
    run_insn(0, 1'b1, 1'b1, 903, 0, "R10 after flush");
    run_insn(10, 1'b1, 1'b1, 904, 0, "R10 plain after flush");

    // R10: flush while a finished instruction waits at the output.
    esc_en = 1'b1;
    send({6'd1, 10'h2aa});
    chk("R10 pending valid", 64'(out_valid), 64'd1);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    chk("R10 flush pending valid", 64'(out_valid), 64'd0);
    chk("R10 flush pending ready", 64'(in_ready), 64'd1);
    run_insn(5, 1'b1, 1'b1, 905, 2, "R10 fresh after pending flush");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule